// File: doc/BRIEF.md
# Select-Gated SPI Slave Serial Port

This block is the receive and transmit port of a serial peripheral bus follower. An outside controller drives the serial clock, and the block never generates one. On each byte, the block shifts one byte out of a local transmit holding register and collects one byte from the data input. When the eighth bit is captured, the received byte is placed in a readable buffer and a sticky completion flag is raised. The local side uses a small parallel register port to program the mode, the clock idle level and the clock edge, to load the next transmit byte, to fetch the received byte and to clear the flag.

The clock, data-in and select pins are brought into the system clock domain through two-flop synchronizers, and clock edges are found in that domain. A state machine sequences the port through three states:
- **OFF**: disabled or misconfigured.
- **IDLE**: enabled but not selected.
- **SHIFT**: selected, with bits moving.

The transitions are:
- OFF→IDLE on *arm*, when the port becomes enabled with a legal setup.
- IDLE→SHIFT on *select*.
- SHIFT→IDLE on *deselect*.
- IDLE→OFF and SHIFT→OFF on *disarm*.

Leaving SHIFT for any reason discards a partial byte and clears the bit counter. The serial output enable follows the raw select pin, so the output is released without synchronizer delay.

Control register (address 0):
- bits [3:0]: mode.
  - 0100: select-pin controlled follower.
  - 0101: follower that ignores select.
  - Any other value keeps the port OFF.
- bit 4: clock idle level.
- bit 5: late-edge option.
- bit 7: enable.

Other addresses:
- Address 1: a write loads the transmit holding byte, and a read returns the received byte.
- Address 2 (status): bit 0 is the completion flag and bit 1 is the configuration-error flag. Writing 1 to bit 0 clears the completion flag.
- Address 3: reads back the transmit holding byte.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset the output enable is low, and the status, received byte and control register all read 0.
- R2: With mode 0100 the port drives its output only while the select pin is low. With mode 0101 it drives its output whenever enabled, regardless of select.
- R3: With the late-edge option clear, the output changes on the clock edge that leaves the idle level, and the input is sampled on the edge that returns to it. Data is sent most-significant bit first.
- R4: With the late-edge option set, the transmit MSB is on the output from selection. Each later bit appears on the edge returning to idle, and the input is sampled on the edge leaving idle.
- R5: On the eighth sample, the assembled byte is readable at address 1 and status bit 0 becomes 1.
- R6: Status bit 0 stays 1 until the local side writes 1 to bit 0 of address 2.
- R7: Raising select mid-byte drops the output enable in the same system cycle and discards the partial byte. The next selection starts a fresh byte from the holding register's MSB.
- R8: Clearing enable mid-byte releases the output, and the next enabled selection starts a fresh byte.
- R9: Late-edge option set together with mode 0101 while enabled sets status bit 1, and the port stays OFF: no output and no completion.
- R10: At each byte end the holding byte is reloaded, so consecutive bytes under one selection each send the current holding byte.
- R11: With idle level 1 the edge roles are mirrored: leaving idle is a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the bus controller |
| sdi | input | 1 | Serial data into the port |
| ss_n | input | 1 | Active-low select |
| sdo | output | 1 | Serial data out of the port |
| sdo_oe | output | 1 | Output enable for sdo, where 0 means high impedance |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |

## Verification
A pin change passes through two synchronizer stages, and the edge it makes is acted upon at the third rising system edge. So the serial output, the received buffer and the flag all settle three cycles after the stimulus. The exception is the output enable, which falls combinationally in the same cycle that select rises. Register writes take effect one edge later, and a disable reaches the state machine one edge after that. The bench holds every serial clock level for four system cycles and samples on the falling system edge at the end of each hold. It checks the output enable one nanosecond after raising select, so every check falls after its result is due and before the next stimulus.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
package spi_slv_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SHIFT = 2'd2
    } slv_state_t;

    localparam logic [3:0] MODE_SEL  = 4'b0100;
    localparam logic [3:0] MODE_FREE = 4'b0101;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_DATA = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_TXRB = 2'd3;

    localparam int CTL_IDLE = 4;
    localparam int CTL_LATE = 5;
    localparam int CTL_EN   = 7;
endpackage

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
module spi_slv_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic meta_q, sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[g];
                    sync_q <= RST_VAL[g];
                end else begin
                    meta_q <= d[g];
                    sync_q <= meta_q;
                end
            end
            assign q[g] = sync_q;
        end
    endgenerate
endmodule

// File: rtl/spi_slv_regs.sv
`timescale 1ns/1ps
module spi_slv_regs import spi_slv_pkg::*; #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          done,
    input  logic [DW-1:0] rx_next,
    output logic          run,
    output logic          sel_ctl,
    output logic          idle_hi,
    output logic          late_edge,
    output logic [DW-1:0] tx_buf
);
    logic [DW-1:0] ctrl_q, rx_buf;
    logic          flag_q, cfg_err, mode_ok, clr_flag;
    logic [3:0]    mode;

    assign mode      = ctrl_q[3:0];
    assign idle_hi   = ctrl_q[CTL_IDLE];
    assign late_edge = ctrl_q[CTL_LATE];
    assign sel_ctl   = (mode == MODE_SEL);
    assign mode_ok   = sel_ctl || (mode == MODE_FREE);
    assign cfg_err   = ctrl_q[CTL_EN] && late_edge && (mode == MODE_FREE);
    assign run       = ctrl_q[CTL_EN] && mode_ok && !cfg_err;
    assign clr_flag  = wr_en && (wr_addr == ADR_STAT) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tx_buf <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_CTRL) ctrl_q <= wr_data;
            if (wr_addr == ADR_DATA) tx_buf <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf <= '0;
            flag_q <= 1'b0;
        end else begin
            if (done) begin
                rx_buf <= rx_next;
                flag_q <= 1'b1;
            end else if (clr_flag) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_CTRL: rd_data = ctrl_q;
            ADR_DATA: rd_data = rx_buf;
            ADR_STAT: rd_data = {{(DW-2){1'b0}}, cfg_err, flag_q};
            ADR_TXRB: rd_data = tx_buf;
            default:  rd_data = '0;
        endcase
    end

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_flag) |=> flag_q);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (flag_q && rx_buf == $past(rx_next)));
endmodule

// File: rtl/spi_slv_core.sv
`timescale 1ns/1ps
module spi_slv_core import spi_slv_pkg::*; #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          sel_ctl,
    input  logic          idle_hi,
    input  logic          late_edge,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic          ss_n_s,
    input  logic          ss_n_raw,
    input  logic [DW-1:0] tx_buf,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          done,
    output logic [DW-1:0] rx_next
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    slv_state_t    state, nxt;
    logic          sck_d, leave, back, samp, shft, selected, in_shift;
    logic [CW-1:0] cnt;
    logic [DW-1:0] tx_sh, rx_sh;
    logic          sdo_q;

    assign leave    = (sck_d == idle_hi) && (sck_s != idle_hi);
    assign back     = (sck_d != idle_hi) && (sck_s == idle_hi);
    assign samp     = late_edge ? leave : back;
    assign shft     = late_edge ? back : leave;
    assign selected = !sel_ctl || !ss_n_s;
    assign in_shift = (state == ST_SHIFT) && (nxt == ST_SHIFT);
    assign done     = in_shift && samp && (cnt == LAST);
    assign rx_next  = {rx_sh[DW-2:0], sdi_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (run) nxt = ST_IDLE;
            ST_IDLE:  if (!run) nxt = ST_OFF;
                      else if (selected) nxt = ST_SHIFT;
            ST_SHIFT: if (!run) nxt = ST_OFF;
                      else if (!selected) nxt = ST_IDLE;
            default:  nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cnt   <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
            sdo_q <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (!in_shift) begin
                cnt <= '0;
                if (state != ST_SHIFT && nxt == ST_SHIFT) begin
                    tx_sh <= late_edge ? (tx_buf << 1) : tx_buf;
                    sdo_q <= late_edge ? tx_buf[DW-1] : 1'b0;
                end
            end else begin
                if (samp) begin
                    rx_sh <= rx_next;
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        tx_sh <= tx_buf;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (shft) begin
                    sdo_q <= tx_sh[DW-1];
                    tx_sh <= tx_sh << 1;
                end
            end
        end
    end

    always_comb begin
        sdo    = sdo_q;
        sdo_oe = (state == ST_SHIFT) && !(sel_ctl && ss_n_raw);
    end

    // R7
    desel_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sel_ctl && ss_n_s && run) |=> (state == ST_IDLE && cnt == '0));

    // R8
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && state != ST_OFF) |=> (state == ST_OFF && !sdo_oe));

    // R3
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_shift && !shft) |=> $stable(sdo_q));

    // R5
    byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt == '0));
endmodule

// File: rtl/spi_sel_slave.sv
`timescale 1ns/1ps
module spi_sel_slave import spi_slv_pkg::*; #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          sdi,
    input  logic          ss_n,
    output logic          sdo,
    output logic          sdo_oe,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [2:0]    pins_s;
    logic          run, sel_ctl, idle_hi, late_edge, done;
    logic [DW-1:0] tx_buf, rx_next;

    spi_slv_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n, sdi, sck}),
        .q     (pins_s)
    );

    spi_slv_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .done      (done),
        .rx_next   (rx_next),
        .run       (run),
        .sel_ctl   (sel_ctl),
        .idle_hi   (idle_hi),
        .late_edge (late_edge),
        .tx_buf    (tx_buf)
    );

    spi_slv_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sel_ctl   (sel_ctl),
        .idle_hi   (idle_hi),
        .late_edge (late_edge),
        .sck_s     (pins_s[0]),
        .sdi_s     (pins_s[1]),
        .ss_n_s    (pins_s[2]),
        .ss_n_raw  (ss_n),
        .tx_buf    (tx_buf),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .done      (done),
        .rx_next   (rx_next)
    );
endmodule

// File: tb/test_spi_sel_slave.sv
`timescale 1ns/1ps
module test_spi_sel_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, sdi = 1'b0, ss_n = 1'b1;
    logic       sdo, sdo_oe;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0, rd_data;
    int         errs = 0, checks = 0;

    always #10 clk = ~clk;

    spi_sel_slave i_spi_sel_slave (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .ss_n(ss_n),
        .sdo(sdo), .sdo_oe(sdo_oe), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Full byte: model expects MSB-first bits of txe, then the reload byte nxt.
    task automatic xfer(input logic [7:0] txe, input logic [7:0] mosi,
                        input logic [7:0] nxt, input bit late, input logic idle,
                        input string tag);
        logic [7:0] v;
        if (late) chk({tag, " R4 first bit"}, sdo, txe[7]);
        for (int i = 0; i < 8; i++) begin
            sdi = mosi[7-i];
            sck = ~idle;
            cyc(4);
            if (!late) chk({tag, " R3 bit"}, sdo, txe[7-i]);
            sck = idle;
            cyc(4);
            if (late) chk({tag, " R4 bit"}, sdo, (i < 7) ? txe[6-i] : nxt[7]);
        end
        rd(2'd2, v);
        chk({tag, " R5 flag"}, v[0], 1);
        rd(2'd1, v);
        chk({tag, " R5 rx byte"}, v, mosi);
        cyc(6);
        rd(2'd2, v);
        chk({tag, " R6 flag held"}, v[0], 1);
        wr(2'd2, 8'h01);
        cyc(1);
        rd(2'd2, v);
        chk({tag, " R6 flag cleared"}, v[0], 0);
    endtask

    task automatic part(input int n, input logic idle);
        for (int i = 0; i < n; i++) begin
            sdi = ~sdi;
            sck = ~idle; cyc(4);
            sck = idle;  cyc(4);
        end
    endtask

    initial begin
        #(200000 * 20);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 oe", sdo_oe, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        rd(2'd1, v); chk("R1 rx", v, 0);
        rd(2'd0, v); chk("R1 ctrl", v, 0);

        // R2/R3/R5/R6: select mode, idle low, early edge
        wr(2'd1, 8'hA5);
        wr(2'd0, 8'h84);
        cyc(2);
        chk("R2 no drive while deselected", sdo_oe, 0);
        ss_n = 1'b0; cyc(4);
        chk("R2 drive when selected", sdo_oe, 1);
        xfer(8'hA5, 8'h3C, 8'hA5, 0, 1'b0, "b1");
        // R10 second byte in same selection reloads holding byte
        xfer(8'hA5, 8'hF0, 8'hA5, 0, 1'b0, "R10");
        ss_n = 1'b1; cyc(4);
        wr(2'd1, 8'h96);
        ss_n = 1'b0; cyc(4);
        xfer(8'h96, 8'h0F, 8'h96, 0, 1'b0, "R10 new");

        // R7: deselect mid-byte
        part(3, 1'b0);
        ss_n = 1'b1;
        #1;
        chk("R7 oe released at once", sdo_oe, 0);
        cyc(6);
        rd(2'd2, v); chk("R7 no completion", v[0], 0);
        ss_n = 1'b0; cyc(4);
        xfer(8'h96, 8'h81, 8'h96, 0, 1'b0, "R7 fresh");
        ss_n = 1'b1; cyc(4);

        // R4/R11: late edge, idle high
        wr(2'd0, 8'h00);
        sck = 1'b1; cyc(4);
        wr(2'd1, 8'hC3);
        wr(2'd0, 8'hB4);
        cyc(3);
        ss_n = 1'b0; cyc(4);
        xfer(8'hC3, 8'h5A, 8'hC3, 1, 1'b1, "R11");
        ss_n = 1'b1; cyc(4);
        wr(2'd0, 8'h00);
        sck = 1'b0; cyc(4);

        // R9: late edge with select ignored
        wr(2'd0, 8'hA5);
        cyc(2);
        rd(2'd2, v); chk("R9 cfg error bit", v[1], 1);
        ss_n = 1'b0;
        part(8, 1'b0);
        chk("R9 no drive", sdo_oe, 0);
        rd(2'd2, v); chk("R9 no completion", v[0], 0);
        ss_n = 1'b1;
        wr(2'd0, 8'h00);
        cyc(2);
        rd(2'd2, v); chk("R9 cfg error clears", v[1], 0);

        // R2: select ignored mode
        wr(2'd1, 8'h7E);
        wr(2'd0, 8'h85);
        cyc(4);
        chk("R2 free mode drives", sdo_oe, 1);
        xfer(8'h7E, 8'h42, 8'h7E, 0, 1'b0, "R2 free");
        wr(2'd0, 8'h00);

        // R8: disable mid-byte
        wr(2'd1, 8'h3C);
        wr(2'd0, 8'h84);
        cyc(2);
        ss_n = 1'b0; cyc(4);
        part(3, 1'b0);
        wr(2'd0, 8'h04);
        cyc(2);
        chk("R8 oe released", sdo_oe, 0);
        rd(2'd2, v); chk("R8 no completion", v[0], 0);
        wr(2'd0, 8'h84);
        cyc(4);
        xfer(8'h3C, 8'hE7, 8'h3C, 0, 1'b0, "R8 fresh");
        ss_n = 1'b1; cyc(4);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule